// File: doc/BRIEF.md
# Bidirectional Serial-to-Parallel Output Driver

This block turns a serial bit stream into 64 parallel output levels. Data is clocked into a 64-stage shift register, one bit per rising clock edge. A bank of 64 level-sensitive latches takes a copy of the register, and a polarity and blanking stage shapes the latched word before it reaches the parallel outputs. The block is meant to feed wide banks of output drivers from a narrow serial link, such as the column drivers of an electrostatic print head.

Two shared serial ports carry the stream. The direction input decides which port receives and which one sends the cascade output. It also decides which end of the parallel vector the data enters from. Each shared port is modelled as separate input, output and output-enable signals. The bit that leaves the far end of the register is presented on the sending port, so several blocks can be chained. The direction can be changed at run time. The register contents are kept when it changes, and later shifts then move the other way.

Parallel output position k (1 to 64) is `drv[k-1]`.

Top module: `serial_parallel_driver`

## Requirements
- R1: While `rst_n` is low the shift register and the latches are cleared. With `pol`=1 and `blank_n`=1 every `drv` bit then reads 0.
- R2: With `dir`=0, `pa_i` is the serial input. Each shifted bit enters position 64 (`drv[63]`) and existing bits move one place toward position 1 (`drv[0]`).
- R3: With `dir`=1, `pb_i` is the serial input. Each shifted bit enters position 1 (`drv[0]`) and existing bits move one place toward position 64 (`drv[63]`).
- R4: The register advances exactly one position on each rising edge of `clk`, and holds between edges.
- R5: The sending port's output carries the register bit at the far end: position 1 when `dir`=0 (on `pb_o`), position 64 when `dir`=1 (on `pa_o`). A bit applied at the serial input reaches it after exactly 64 rising edges, and not after 63.
- R6: Shifting is unaffected by `le`, `blank_n` and `pol`. Bits shifted while the latches hold or while blanked are found in the register when the latches are next opened.
- R7: While `le` is 1 the latches are transparent, so a shift made while `le` is 1 shows at `drv` in the same clock period.
- R8: After `le` falls, the latches hold their value, and further shifts do not change `drv`.
- R9: While `blank_n` is 0 every `drv` bit is 0, whatever the latch contents and `pol`.
- R10: With `blank_n`=1, `pol`=1 passes the latch bits to `drv` unchanged, and `pol`=0 inverts every bit.
- R11: Exactly one output-enable is high: `pb_oe`=1 when `dir`=0 and `pa_oe`=1 when `dir`=1.
- R12: Changing `dir` without a clock edge leaves the register contents unchanged. The next shift moves the data in the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir | input | 1 | 0: A receives and data moves toward position 1; 1: B receives and data moves toward position 64 |
| pa_i | input | 1 | Port A pad input |
| pa_o | output | 1 | Port A pad output (cascade data) |
| pa_oe | output | 1 | Port A output enable |
| pb_i | input | 1 | Port B pad input |
| pb_o | output | 1 | Port B pad output (cascade data) |
| pb_oe | output | 1 | Port B output enable |
| le | input | 1 | Latch enable, transparent while high |
| blank_n | input | 1 | Active-low blanking, forces all outputs to 0 |
| pol | input | 1 | 1: outputs true, 0: outputs inverted |
| drv | output | 64 | Parallel outputs, `drv[k-1]` is position k |

## Verification
The hardest condition to reach from the ports is a register whose contents differ from what `drv` shows. It only arises when the latches are closed, the outputs are blanked, or the direction changed with data still in flight. The bench reaches it by filling the register with a known pattern while `le` is high. It then drops `le`, or pulls `blank_n` low, and keeps shifting. Reopening the latches afterwards exposes the hidden contents at `drv`, which are compared against a bench-side model of the register. The 64-edge cascade delay is checked by flushing the register with zeros, inserting a single one, and watching the sending port on edges 63 and 64.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // Direction encoding carried on the dir pin
  typedef enum logic {
    SHIFT_DOWN = 1'b0,  // enter at top index, move toward index 0
    SHIFT_UP   = 1'b1   // enter at index 0, move toward top index
  } shift_dir_e;

  localparam int unsigned DEF_WIDTH = 64;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain
  import sipo_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  shift_dir_e       dir,
  input  logic             sin,
  output logic             sout,
  output logic [WIDTH-1:0] q
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [WIDTH-1:0] q_nxt;

  // Next-state: each stage takes its neighbour on the side data comes from
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic from_lo;
    logic from_hi;
    if (i == 0) begin : g_lo_end
      assign from_lo = sin;
    end else begin : g_lo_mid
      assign from_lo = q[i-1];
    end
    if (i == TOP) begin : g_hi_end
      assign from_hi = sin;
    end else begin : g_hi_mid
      assign from_hi = q[i+1];
    end
    always_comb begin
      q_nxt[i] = (dir == SHIFT_UP) ? from_lo : from_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

  always_comb begin
    sout = (dir == SHIFT_UP) ? q[TOP] : q[0];
  end
endmodule

// File: rtl/sipo_latch_bank.sv
module sipo_latch_bank
  import sipo_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             rst_n,
  input  logic             open,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // Level-sensitive storage: transparent while open, holds when closed
  always_latch begin
    if (!rst_n) begin
      q = '0;
    end else if (open) begin
      q = d;
    end
  end
endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate
  import sipo_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             blank_n,
  input  logic             pol,
  input  logic [WIDTH-1:0] lat,
  output logic [WIDTH-1:0] drv
);
  logic [WIDTH-1:0] shaped;

  always_comb begin
    shaped = pol ? lat : ~lat;
    drv    = blank_n ? shaped : '0;
  end
endmodule

// File: rtl/serial_parallel_driver.sv
module serial_parallel_driver
  import sipo_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir,
  input  logic             pa_i,
  output logic             pa_o,
  output logic             pa_oe,
  input  logic             pb_i,
  output logic             pb_o,
  output logic             pb_oe,
  input  logic             le,
  input  logic             blank_n,
  input  logic             pol,
  output logic [WIDTH-1:0] drv
);
  shift_dir_e       dir_e;
  logic             ser_in;
  logic             ser_out;
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] lat_q;

  // Port steering: the receiving port feeds the chain, the other one sends
  always_comb begin
    dir_e  = shift_dir_e'(dir);
    ser_in = (dir_e == SHIFT_UP) ? pb_i : pa_i;
    pa_oe  = (dir_e == SHIFT_UP);
    pb_oe  = (dir_e == SHIFT_DOWN);
    pa_o   = ser_out;
    pb_o   = ser_out;
  end

  sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .dir   (dir_e),
    .sin   (ser_in),
    .sout  (ser_out),
    .q     (chain_q)
  );

  sipo_latch_bank #(.WIDTH(WIDTH)) u_latch (
    .rst_n (rst_n),
    .open  (le),
    .d     (chain_q),
    .q     (lat_q)
  );

  sipo_out_gate #(.WIDTH(WIDTH)) u_gate (
    .blank_n (blank_n),
    .pol     (pol),
    .lat     (lat_q),
    .drv     (drv)
  );
endmodule

// File: rtl/sipo_driver_chk.sv
module sipo_driver_chk #(
  parameter int unsigned WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir,
  input logic             pa_i,
  input logic             pa_o,
  input logic             pa_oe,
  input logic             pb_i,
  input logic             pb_o,
  input logic             pb_oe,
  input logic             le,
  input logic             blank_n,
  input logic             pol,
  input logic [WIDTH-1:0] drv
);
  logic open_view;
  assign open_view = le && blank_n && pol;

  AST_ONE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({pa_oe, pb_oe}) == 1) && (pa_oe == dir)); // R11

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (drv == '0)); // R9

  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && $past(!le) && $stable(pol) && $stable(blank_n)) |-> $stable(drv)); // R8

  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (open_view && $past(open_view) && !$past(dir))
      |-> (drv == {$past(pa_i), $past(drv[WIDTH-1:1])})); // R2

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (open_view && $past(open_view) && $past(dir))
      |-> (drv == {$past(drv[WIDTH-2:0]), $past(pb_i)})); // R3

  AST_SOUT_END: assert property (@(posedge clk) disable iff (!rst_n)
    open_view |-> (dir ? (pa_o == drv[WIDTH-1]) : (pb_o == drv[0]))); // R5
endmodule

bind serial_parallel_driver sipo_driver_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_serial_parallel_driver.sv
module sim_serial_parallel_driver;
  localparam int W   = 64;
  localparam int PER = 10;

  logic         clk = 0;
  logic         rst_n, dir, pa_i, pb_i, le, blank_n, pol;
  logic         pa_o, pa_oe, pb_o, pb_oe;
  logic [W-1:0] drv;

  logic [W-1:0] m_sr;   // bench model of the register
  logic [W-1:0] m_lat;  // bench model of the latches
  int           n_chk = 0;
  int           n_bad = 0;

  always #(PER/2) clk = ~clk;

  serial_parallel_driver #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .dir(dir),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe),
    .le(le), .blank_n(blank_n), .pol(pol), .drv(drv)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expect_drv();
    if (!blank_n) return '0;
    return pol ? m_lat : ~m_lat;
  endfunction

  // One shift: drive the receiving port, take one edge, settle off the edge
  task automatic shift_bit(input logic b);
    if (dir) pb_i = b; else pa_i = b;
    @(posedge clk);
    #(PER/4);
    if (dir) m_sr = {m_sr[W-2:0], b};
    else     m_sr = {b, m_sr[W-1:1]};
    if (le) m_lat = m_sr;
  endtask

  task automatic set_le(input logic v);
    le = v;
    #1;
    if (le) m_lat = m_sr;
  endtask

  task automatic t_reset();
    rst_n = 0; dir = 0; pa_i = 0; pb_i = 0; le = 1; blank_n = 1; pol = 1;
    m_sr = '0; m_lat = '0;
    repeat (3) @(posedge clk);
    #(PER/4);
    check("R1 drv after reset", drv, '0);
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R11 oe with dir=0", {62'b0, pa_oe, pb_oe}, 64'b01);
  endtask

  task automatic t_fwd();
    dir = 0; set_le(1);
    for (int i = 0; i < W; i++) begin
      shift_bit(logic'((i * 7 + 3) % 5 == 0));
      if (i % 8 == 0) check("R2 R4 R7 dir=0 shift", drv, expect_drv());
    end
    check("R2 dir=0 full word", drv, expect_drv());
    check("R5 pb_o is position 1", {63'b0, pb_o}, {63'b0, m_sr[0]});
  endtask

  task automatic t_cascade();
    dir = 0; set_le(0);
    for (int i = 0; i < W; i++) shift_bit(1'b0);
    shift_bit(1'b1);
    for (int i = 1; i < W - 1; i++) shift_bit(1'b0);
    check("R5 after 63 edges", {63'b0, pb_o}, 64'b0);
    shift_bit(1'b0);
    check("R5 after 64 edges", {63'b0, pb_o}, 64'b1);
    set_le(1);
    check("R6 register shifted while le=0", drv, expect_drv());
  endtask

  task automatic t_rev();
    dir = 1; set_le(1);
    #1;
    check("R11 oe with dir=1", {62'b0, pa_oe, pb_oe}, 64'b10);
    for (int i = 0; i < 20; i++) shift_bit(logic'(i % 3 == 0));
    check("R3 dir=1 shift", drv, expect_drv());
    check("R3 bit enters drv[0]", {63'b0, drv[0]}, {63'b0, m_sr[0]});
    check("R5 pa_o is position 64", {63'b0, pa_o}, {63'b0, m_sr[W-1]});
  endtask

  task automatic t_hold();
    logic [W-1:0] held;
    dir = 0; set_le(1);
    for (int i = 0; i < 10; i++) shift_bit(1'b1);
    set_le(0);
    held = drv;
    for (int i = 0; i < 5; i++) shift_bit(logic'(i[0]));
    check("R8 drv held after le fell", drv, held);
    set_le(1);
    check("R7 R6 latches reopen to register", drv, expect_drv());
  endtask

  task automatic t_blank();
    set_le(1);
    blank_n = 0; pol = 1;
    #1;
    check("R9 blank pol=1", drv, '0);
    pol = 0;
    #1;
    check("R9 blank pol=0", drv, '0);
    for (int i = 0; i < 4; i++) shift_bit(1'b1);
    check("R9 blank while shifting", drv, '0);
    blank_n = 1; pol = 1;
    #1;
    check("R6 shift under blank kept", drv, expect_drv());
  endtask

  task automatic t_pol();
    set_le(1);
    pol = 0;
    #1;
    check("R10 pol=0 inverts", drv, ~m_lat);
    pol = 1;
    #1;
    check("R10 pol=1 passes", drv, m_lat);
  endtask

  task automatic t_dirswap();
    set_le(1); dir = 0;
    for (int i = 0; i < W; i++) shift_bit(logic'(i < 16));
    dir = 1;
    #1;
    check("R12 dir change keeps contents", drv, expect_drv());
    shift_bit(1'b0);
    check("R12 next shift goes up", drv, expect_drv());
    dir = 0;
    #1;
    shift_bit(1'b1);
    check("R12 next shift goes down", drv, expect_drv());
  endtask

  initial begin
    #(PER * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fwd();
    t_cascade();
    t_rev();
    t_hold();
    t_blank();
    t_pol();
    t_dirswap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule